// File: doc/BRIEF.md
# SPI Status Register Write Guard

This block sits on the slave side of a serial memory's SPI port and handles the commands that govern write permission and the block-protection settings. It tracks a write-enable latch and an arming flag. It keeps two status registers and decides whether a status write may alter them. That decision depends on the arming, the exact length of the data phase, the level of the hardware write-protect pin and the lock bit held in the status register.

All SPI inputs are brought into the system clock domain through a synchronizer. Bits are taken on rising SCK edges while CE# is low. Nothing is decoded until CE# returns high, and each instruction takes effect in that cycle. The register contents are always visible on the outputs. A host reads them through this block's parent and sees the result of every completed frame.

Top module: `spi_status_guard`

## Requirements
- R1: After reset, `status_o`, `status1_o` and `wel_o` are all zero.
- R2: A frame changes nothing while CE# is still low. Its effect appears only after CE# rises, within 8 system clocks.
- R3: Opcode 0x06 sets the write-enable latch (`wel_o`, also `status_o` bit 1) and arms a status write. Opcode 0x50 arms a status write and leaves the latch as it is. Clocks beyond the 8 opcode bits do not prevent these commands from acting.
- R4: Opcode 0x04 clears the write-enable latch and the auto-increment bit (`status_o` bit 6), and it disarms.
- R5: Opcode 0x01 acts only when the previous completed frame was 0x06 or 0x50. Every frame of 8 or more bits uses up the arming. A frame of fewer than 8 bits has no effect and keeps the arming.
- R6: A status write commits only with exactly 8 or 16 data bits. The first data byte sets `status_o` bits 7 (lock), 3 and 2. A second byte also sets `status1_o` bits 4 and 3. All other bits are read-only.
- R7: With write-protect low and the lock bit set, a status write changes no register bit.
- R8: With write-protect low and the lock bit clear, a status write may set the lock bit and change the other protection bits in the same frame. The lock bit cannot fall while write-protect is low.
- R9: With write-protect high, a status write may change every writable bit, including clearing the lock bit.
- R10: A committed status write clears the write-enable latch. A rejected one leaves it unchanged.
- R11: SCK idle low and SCK idle high (SPI modes 0 and 3) both work, with the most significant bit first.
- R12: Any other opcode changes no register bit and does not set the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than 4x SCK |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | SPI chip select, active low |
| sck_i | input | 1 | SPI serial clock |
| si_i | input | 1 | SPI serial data in |
| wp_n_i | input | 1 | Hardware write-protect, active low |
| status_o | output | 8 | Status register; bit 1 is the write-enable latch |
| status1_o | output | 8 | Second status register |
| wel_o | output | 1 | Write-enable latch |

## Verification
The assertions assume that SCK, SI, CE# and WP# are sampled in the system clock domain. Each level must therefore hold for at least two system clocks, and CE# must never move in the same clock as an SCK edge. The bench holds every SCK phase for four system clocks and changes SI only while SCK is low. It moves WP# and CE# only while SCK is idle, so every rising SCK edge and every CE# edge is seen exactly once and in order.

// File: rtl/spi_sg_pkg.sv
package spi_sg_pkg;
    localparam int BYTE_W = 8;

    localparam logic [7:0] OPC_WR_ENABLE  = 8'h06;
    localparam logic [7:0] OPC_WR_DISABLE = 8'h04;
    localparam logic [7:0] OPC_ARM_STATUS = 8'h50;
    localparam logic [7:0] OPC_WR_STATUS  = 8'h01;

    localparam logic [7:0] SR0_WR_MASK = 8'h8C;
    localparam logic [7:0] SR1_WR_MASK = 8'h18;
    localparam int         SR0_LOCK    = 7;
    localparam int         SR0_AINC    = 6;

    typedef struct packed {
        logic       wel;
        logic       armed;
        logic [7:0] sr0;
        logic [7:0] sr1;
    } guard_state_t;
endpackage

// File: rtl/spi_sg_sync.sv
module spi_sg_sync #(
    parameter int               WIDTH   = 4,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[s] <= RST_VAL;
                end else if (s == 0) begin
                    stage_q[s] <= d_i;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s - 1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_sg_shifter.sv
module spi_sg_shifter #(
    parameter int OP_W    = 8,
    parameter int DATA_W  = 16,
    parameter int CNT_MAX = 63,
    localparam int CNT_W  = $clog2(CNT_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              sck_s,
    input  logic              si_s,
    output logic              frame_end_o,
    output logic [OP_W-1:0]   opcode_o,
    output logic [DATA_W-1:0] data_o,
    output logic [CNT_W-1:0]  bit_cnt_o
);
    localparam logic [CNT_W-1:0] CNT_TOP   = CNT_W'(CNT_MAX);
    localparam logic [CNT_W-1:0] CNT_OPEND = CNT_W'(OP_W);

    typedef struct packed {
        logic              cs_prev;
        logic              sck_prev;
        logic [CNT_W-1:0]  cnt;
        logic [OP_W-1:0]   op;
        logic [DATA_W-1:0] dat;
    } shift_state_t;

    shift_state_t s_d, s_q;
    logic frame_start, frame_end, sck_rise;

    always_comb begin
        s_d          = s_q;
        s_d.cs_prev  = cs_n_s;
        s_d.sck_prev = sck_s;
        frame_start  = s_q.cs_prev && !cs_n_s;
        frame_end    = !s_q.cs_prev && cs_n_s;
        sck_rise     = !s_q.sck_prev && sck_s && !cs_n_s;
        if (frame_start) begin
            s_d.cnt = '0;
            s_d.op  = '0;
            s_d.dat = '0;
        end else if (sck_rise) begin
            if (s_q.cnt < CNT_OPEND) begin
                s_d.op = {s_q.op[OP_W-2:0], si_s};
            end else begin
                s_d.dat = {s_q.dat[DATA_W-2:0], si_s};
            end
            if (s_q.cnt != CNT_TOP) begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{cs_prev: 1'b1, sck_prev: 1'b0, cnt: '0, op: '0, dat: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign frame_end_o = frame_end;
    assign opcode_o    = s_q.op;
    assign data_o      = s_q.dat;
    assign bit_cnt_o   = s_q.cnt;

    AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt == CNT_TOP && !frame_start) |=> (s_q.cnt == CNT_TOP)); // R6
    AST_OPCODE_FROZEN_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt >= CNT_OPEND && !frame_start) |=> $stable(s_q.op)); // R11
endmodule

// File: rtl/spi_status_guard.sv
module spi_status_guard #(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_MAX     = 63,
    localparam int CNT_W      = $clog2(CNT_MAX + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n_i,
    input  logic       sck_i,
    input  logic       si_i,
    input  logic       wp_n_i,
    output logic [7:0] status_o,
    output logic [7:0] status1_o,
    output logic       wel_o
);
    import spi_sg_pkg::*;

    localparam int DATA_W = 2 * BYTE_W;
    localparam logic [CNT_W-1:0] LEN_OP    = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LEN_ONE   = CNT_W'(2 * BYTE_W);
    localparam logic [CNT_W-1:0] LEN_TWO   = CNT_W'(3 * BYTE_W);

    logic [3:0]        pins_s;
    logic              cs_n_s, sck_s, si_s, wp_n_s;
    logic              frame_end;
    logic [BYTE_W-1:0] opcode;
    logic [DATA_W-1:0] data;
    logic [CNT_W-1:0]  bit_cnt;

    spi_sg_sync #(
        .WIDTH  (4),
        .STAGES (SYNC_STAGES),
        .RST_VAL(4'b1001)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  ({cs_n_i, sck_i, si_i, wp_n_i}),
        .q_o  (pins_s)
    );

    assign {cs_n_s, sck_s, si_s, wp_n_s} = pins_s;

    spi_sg_shifter #(
        .OP_W   (BYTE_W),
        .DATA_W (DATA_W),
        .CNT_MAX(CNT_MAX)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n_s     (cs_n_s),
        .sck_s      (sck_s),
        .si_s       (si_s),
        .frame_end_o(frame_end),
        .opcode_o   (opcode),
        .data_o     (data),
        .bit_cnt_o  (bit_cnt)
    );

    guard_state_t g_d, g_q;
    logic         frame_ok, len_one, len_two, locked, commit;
    logic [7:0]   byte_a, byte_b;

    always_comb begin
        g_d      = g_q;
        frame_ok = frame_end && (bit_cnt >= LEN_OP);
        len_one  = (bit_cnt == LEN_ONE);
        len_two  = (bit_cnt == LEN_TWO);
        locked   = !wp_n_s && g_q.sr0[SR0_LOCK];
        byte_a   = len_two ? data[DATA_W-1:BYTE_W] : data[BYTE_W-1:0];
        byte_b   = data[BYTE_W-1:0];
        commit   = frame_ok && (opcode == OPC_WR_STATUS) && g_q.armed
                   && (len_one || len_two) && !locked;
        if (frame_ok) begin
            g_d.armed = 1'b0;
            unique case (opcode)
                OPC_WR_ENABLE: begin
                    g_d.wel   = 1'b1;
                    g_d.armed = 1'b1;
                end
                OPC_ARM_STATUS: begin
                    g_d.armed = 1'b1;
                end
                OPC_WR_DISABLE: begin
                    g_d.wel           = 1'b0;
                    g_d.sr0[SR0_AINC] = 1'b0;
                end
                default: ;
            endcase
        end
        if (commit) begin
            g_d.sr0 = (g_q.sr0 & ~SR0_WR_MASK) | (byte_a & SR0_WR_MASK);
            if (len_two) begin
                g_d.sr1 = (g_q.sr1 & ~SR1_WR_MASK) | (byte_b & SR1_WR_MASK);
            end
            g_d.wel = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q <= '0;
        end else begin
            g_q <= g_d;
        end
    end

    assign status_o  = {g_q.sr0[7:2], g_q.wel, 1'b0};
    assign status1_o = g_q.sr1;
    assign wel_o     = g_q.wel;

    AST_WEL_MOVES_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(g_q.wel) |-> $past(frame_end)); // R2
    AST_WRITE_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(g_q.sr0 & SR0_WR_MASK) |-> $past(g_q.armed)); // R5
    AST_LOCK_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && !wp_n_s && g_q.sr0[SR0_LOCK])
            |=> ($stable(g_q.sr0 & SR0_WR_MASK) && $stable(g_q.sr1))); // R7
    AST_LOCK_NO_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(g_q.sr0[SR0_LOCK]) |-> $past(wp_n_s)); // R8
    AST_DISABLE_DROPS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && bit_cnt >= LEN_OP && opcode == OPC_WR_DISABLE) |=> !g_q.wel); // R4
    AST_SR1_WRITE_DROPS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(g_q.sr1) |-> !g_q.wel); // R10
endmodule

// File: tb/tb_spi_status_guard.sv
module tb_spi_status_guard;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, sck = 1'b0, si = 1'b0, wp_n = 1'b1;
    logic [7:0] status, status1;
    logic       wel;
    int         checks = 0;
    int         failures = 0;

    always #10 clk = ~clk;

    spi_status_guard dut (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sck_i(sck), .si_i(si),
        .wp_n_i(wp_n), .status_o(status), .status1_o(status1), .wel_o(wel)
    );

    typedef struct packed {
        logic [7:0]  op;
        logic [4:0]  nd;
        logic [15:0] dat;
        logic        wp;
        logic [7:0]  exp_st;
        logic [7:0]  exp_s1;
        logic        exp_wel;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        {8'h06, 5'd0,  16'h0000, 1'b1, 8'h02, 8'h00, 1'b1},
        {8'h01, 5'd8,  16'hFF00, 1'b1, 8'h8C, 8'h00, 1'b0},
        {8'h01, 5'd8,  16'h0000, 1'b1, 8'h8C, 8'h00, 1'b0},
        {8'h50, 5'd0,  16'h0000, 1'b1, 8'h8C, 8'h00, 1'b0},
        {8'h01, 5'd16, 16'h00FF, 1'b1, 8'h00, 8'h18, 1'b0},
        {8'h06, 5'd0,  16'h0000, 1'b1, 8'h02, 8'h18, 1'b1},
        {8'h01, 5'd12, 16'h8C00, 1'b1, 8'h02, 8'h18, 1'b1},
        {8'h50, 5'd0,  16'h0000, 1'b0, 8'h02, 8'h18, 1'b1},
        {8'h01, 5'd8,  16'h8400, 1'b0, 8'h84, 8'h18, 1'b0},
        {8'h06, 5'd0,  16'h0000, 1'b0, 8'h86, 8'h18, 1'b1},
        {8'h01, 5'd16, 16'h0000, 1'b0, 8'h86, 8'h18, 1'b1},
        {8'h50, 5'd0,  16'h0000, 1'b1, 8'h86, 8'h18, 1'b1},
        {8'h01, 5'd8,  16'h0800, 1'b1, 8'h08, 8'h18, 1'b0},
        {8'hAB, 5'd0,  16'h0000, 1'b1, 8'h08, 8'h18, 1'b0},
        {8'h01, 5'd8,  16'hFF00, 1'b1, 8'h08, 8'h18, 1'b0},
        {8'h06, 5'd0,  16'h0000, 1'b1, 8'h0A, 8'h18, 1'b1},
        {8'h04, 5'd0,  16'h0000, 1'b1, 8'h08, 8'h18, 1'b0},
        {8'h01, 5'd8,  16'hFF00, 1'b1, 8'h08, 8'h18, 1'b0}
    };

    function automatic string vec_req(input int i);
        case (i)
            1, 4, 6: return "R6";
            2, 14, 17: return "R5";
            8:  return "R8";
            10: return "R7";
            12: return "R9";
            13: return "R12";
            16: return "R4";
            default: return "R3";
        endcase
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check8(input string req, input string what,
                          input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic begin_frame(input logic mode3);
        sck = mode3;
        wait_clk(4);
        cs_n = 1'b0;
        wait_clk(4);
    endtask

    task automatic shift_bit(input logic b);
        sck = 1'b0;
        si  = b;
        wait_clk(4);
        sck = 1'b1;
        wait_clk(4);
    endtask

    task automatic end_frame(input logic mode3);
        if (!mode3) begin
            sck = 1'b0;
            wait_clk(4);
        end
        cs_n = 1'b1;
        wait_clk(12);
    endtask

    task automatic send(input logic [7:0] op, input int nd, input logic [15:0] dat,
                        input logic wp, input logic mode3);
        wp_n = wp;
        begin_frame(mode3);
        for (int b = 7; b >= 0; b--) shift_bit(op[b]);
        for (int j = 0; j < nd; j++) shift_bit(dat[15-j]);
        end_frame(mode3);
    endtask

    task automatic check_all(input string req, input logic [7:0] st,
                             input logic [7:0] s1, input logic w);
        check8(req, "status", status, st);
        check8(req, "status1", status1, s1);
        check8(req, "wel", {7'd0, wel}, {7'd0, w});
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        check_all("R1", 8'h00, 8'h00, 1'b0);

        for (int i = 0; i < NV; i++) begin
            send(VEC[i].op, int'(VEC[i].nd), VEC[i].dat, VEC[i].wp, 1'b0);
            check8(vec_req(i), "status", status, VEC[i].exp_st);
            check8(vec_req(i), "status1", status1, VEC[i].exp_s1);
            check8((VEC[i].op == 8'h01) ? "R10" : vec_req(i), "wel",
                   {7'd0, wel}, {7'd0, VEC[i].exp_wel});
        end

        // R2: nothing acts before CE# rises
        wp_n = 1'b1;
        begin_frame(1'b0);
        for (int b = 7; b >= 0; b--) shift_bit(logic'(8'h06 >> b));
        wait_clk(12);
        check8("R2", "wel mid-frame", {7'd0, wel}, 8'h00);
        end_frame(1'b0);
        check8("R2", "wel after end", {7'd0, wel}, 8'h01);

        // R11: mode 3 framing, MSB first, two data bytes
        send(8'h50, 0, 16'h0000, 1'b1, 1'b1);
        send(8'h01, 16, 16'h0410, 1'b1, 1'b1);
        check_all("R11", 8'h04, 8'h10, 1'b0);

        // R5: a frame under 8 bits keeps the arming
        send(8'h50, 0, 16'h0000, 1'b1, 1'b0);
        begin_frame(1'b0);
        shift_bit(1'b1); shift_bit(1'b0); shift_bit(1'b1);
        end_frame(1'b0);
        send(8'h01, 8, 16'h8000, 1'b1, 1'b0);
        check_all("R5", 8'h80, 8'h10, 1'b0);

        // R3: extra clocks after a single-byte opcode
        send(8'h06, 5, 16'hF800, 1'b1, 1'b0);
        check_all("R3", 8'h82, 8'h10, 1'b1);

        // R1: reset again mid-run
        rst_n = 1'b0;
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(3);
        check_all("R1", 8'h00, 8'h00, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule